// File: doc/BRIEF.md
# Floating-Point Status Word Update Unit

This block owns the 32-bit floating-point status word that sits beside a floating-point datapath. It decodes the rounding mode and the flush-to-zero control from that word and drives them to the datapath. After each arithmetic operation it folds the IEEE exception flags that the operation raised into a sticky field. If any raised flag is also enabled in the word, it requests a trap.

A compare operation also delivers a four-way relation (greater, less, equal, unordered) and a 5-bit condition selector. Selector bit 1..4 gives the condition value for that relation. The compare either writes one addressed condition bit or pushes the value into a ten-deep condition queue that trails the primary condition bit. Software can overwrite the whole word at any time. Such a write wins over an operation presented in the same cycle, and that operation is then dropped.

Each cycle is classified as one of four update kinds by an enumerated selector: HOLD (nothing presented), LOAD (software write), ARITH (arithmetic result flags) and CMP (compare with flags). The word register takes the next value for that kind at the clock edge. The transitions are: any kind to LOAD when `sw_we` is high; to CMP when `op_valid` and `op_is_cmp` are high without a write; to ARITH when `op_valid` is high alone; otherwise HOLD.

Top module: `fpsw_unit`

## Requirements
- R1: During and directly after reset, `status` is 0 and `trap_req` is 0.
- R2: When `sw_we` is high, `status` equals `sw_wdata` after the next clock edge. This holds even when `op_valid` is high in the same cycle: that operation is then ignored and raises no trap.
- R3: `round_mode` equals status bits 10:9 (0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf). `flush_en` equals status bit 5. Both show a software write in the cycle after the write.
- R4: On an accepted operation, `op_flags` (bit0 inexact, bit1 underflow, bit2 overflow, bit3 divide-by-zero, bit4 invalid) is ORed into status bits 31:27 at the same positions. Set bits stay set until software rewrites them.
- R5: An accepted arithmetic operation with `op_flags` equal to 0 leaves `status` unchanged.
- R6: `trap_req` is high for the cycle after an accepted operation whose `op_flags` ANDed with status bits 4:0 (the enables) is non-zero. Otherwise it is low.
- R7: The compare result is `cmp_sel` bit 4 for greater (`cmp_rel`=0), bit 3 for less (1), bit 2 for equal (2) and bit 1 for unordered (3). `cmp_sel` bit 0 (signaling compare) has no effect on `status`.
- R8: A compare with `cmp_idx` y in 1..11 sets status bit 22−y to the result and changes no other condition or control bit.
- R9: A compare with `cmp_idx` 0 moves bits 21:12 to 20:11, copies the old bit 26 into bit 21 and writes the result into bit 26.
- R10: A compare that also raises flags merges them into bits 31:27 and applies the condition update in the same cycle.
- R11: A compare with `cmp_idx` 12..15 changes no condition bit, though its flags are still merged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_we | input | 1 | Software write strobe for the whole word |
| sw_wdata | input | 32 | Word value to load |
| op_valid | input | 1 | An operation completed this cycle |
| op_is_cmp | input | 1 | The completed operation is a compare |
| op_flags | input | 5 | Raised exception flags |
| cmp_rel | input | 2 | Compare relation: 0 gt, 1 lt, 2 eq, 3 unordered |
| cmp_sel | input | 5 | Condition selector; bit 0 selects a signaling compare |
| cmp_idx | input | 4 | 0 queues the result, 1..11 target a condition bit |
| status | output | 32 | Current status word |
| round_mode | output | 2 | Decoded rounding mode |
| flush_en | output | 1 | Flush denormal inputs and results to zero |
| trap_req | output | 1 | Trap request, one cycle after the operation |

## Verification
The embedded assertions check these relations on every cycle: the priority of a software write, the trap timing and its cause, that the sticky flags never clear except on a write, that flag-free arithmetic holds the word, the queue shift and that compares never touch the control bits. The exact value written by a compare for each relation and selector, the targeted bit position for each index, and the ignored indices are shown only by the bench. It compares the word against its own model after every cycle, for directed cases and for seeded random traffic.

// File: rtl/fpsw_pkg.sv
package fpsw_pkg;
    localparam int WORD_W   = 32;
    localparam int NFLAG    = 5;
    localparam int QLEN     = 10;
    localparam int IDX_W    = 4;
    localparam int FLAG_LO  = 27;
    localparam int PRIM_BIT = 26;
    localparam int CQ_TOP   = 21;
    localparam int RM_LO    = 9;
    localparam int FTZ_BIT  = 5;
    localparam int NTARGET  = QLEN + 1;

    typedef enum logic [1:0] {
        REL_GT    = 2'd0,
        REL_LT    = 2'd1,
        REL_EQ    = 2'd2,
        REL_UNORD = 2'd3
    } fp_rel_e;

    typedef enum logic [1:0] {
        UPD_HOLD  = 2'd0,
        UPD_LOAD  = 2'd1,
        UPD_ARITH = 2'd2,
        UPD_CMP   = 2'd3
    } upd_kind_e;

    typedef enum logic [1:0] {
        RND_NEAREST = 2'd0,
        RND_ZERO    = 2'd1,
        RND_UP      = 2'd2,
        RND_DOWN    = 2'd3
    } rnd_mode_e;
endpackage

// File: rtl/fpsw_flag_merge.sv
module fpsw_flag_merge
    import fpsw_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int NF = NFLAG,
    parameter int LO = FLAG_LO
) (
    input  logic [W-1:0]  word_in,
    input  logic          en,
    input  logic [NF-1:0] flags,
    output logic [W-1:0]  word_out,
    output logic          trap_hit
);
    localparam int HI = LO + NF - 1;

    always_comb begin
        word_out = word_in;
        trap_hit = 1'b0;
        if (en) begin
            word_out[HI:LO] = word_in[HI:LO] | flags;
            trap_hit        = |(flags & word_in[NF-1:0]);
        end
    end
endmodule

// File: rtl/fpsw_cond_update.sv
module fpsw_cond_update
    import fpsw_pkg::*;
#(
    parameter int W    = WORD_W,
    parameter int QL   = QLEN,
    parameter int IW   = IDX_W,
    parameter int TOP  = CQ_TOP,
    parameter int PRIM = PRIM_BIT
) (
    input  logic [W-1:0]  word_in,
    input  logic          en,
    input  logic [1:0]    rel,
    input  logic [4:0]    sel,
    input  logic [IW-1:0] idx,
    output logic [W-1:0]  word_out
);
    localparam int NT = QL + 1;

    logic          result;
    logic [NT-1:0] tgt_hit;
    fp_rel_e       rel_e;

    assign rel_e = fp_rel_e'(rel);

    always_comb begin
        unique case (rel_e)
            REL_GT:    result = sel[4];
            REL_LT:    result = sel[3];
            REL_EQ:    result = sel[2];
            REL_UNORD: result = sel[1];
        endcase
    end

    // one decoder per addressable condition bit: target y hits bit TOP+1-y
    for (genvar g = 0; g < NT; g++) begin : g_tgt
        assign tgt_hit[g] = (idx == IW'(g + 1));
    end

    always_comb begin
        word_out = word_in;
        if (en) begin
            if (idx == '0) begin
                word_out[TOP-1 -: QL] = word_in[TOP -: QL];
                word_out[TOP]         = word_in[PRIM];
                word_out[PRIM]        = result;
            end else begin
                for (int k = 0; k < NT; k++) begin
                    if (tgt_hit[k]) word_out[TOP-k] = result;
                end
            end
        end
    end
endmodule

// File: rtl/fpsw_mode_decode.sv
module fpsw_mode_decode
    import fpsw_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [W-1:0] word,
    output logic [1:0]   round_mode,
    output logic         flush_en
);
    rnd_mode_e mode;

    always_comb begin
        unique case (word[RM_LO+1:RM_LO])
            2'd0: mode = RND_NEAREST;
            2'd1: mode = RND_ZERO;
            2'd2: mode = RND_UP;
            2'd3: mode = RND_DOWN;
        endcase
    end

    assign round_mode = mode;
    assign flush_en   = word[FTZ_BIT];
endmodule

// File: rtl/fpsw_unit.sv
module fpsw_unit
    import fpsw_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int NF = NFLAG,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_we,
    input  logic [W-1:0]  sw_wdata,
    input  logic          op_valid,
    input  logic          op_is_cmp,
    input  logic [NF-1:0] op_flags,
    input  logic [1:0]    cmp_rel,
    input  logic [4:0]    cmp_sel,
    input  logic [IW-1:0] cmp_idx,
    output logic [W-1:0]  status,
    output logic [1:0]    round_mode,
    output logic          flush_en,
    output logic          trap_req
);
    localparam int FHI = FLAG_LO + NF - 1;

    upd_kind_e    kind;
    logic [W-1:0] word_q, word_d;
    logic [W-1:0] merged, cmp_word;
    logic         trap_hit, trap_q;
    logic         op_take;

    // update-kind selector: software write first, then compare, then arithmetic
    always_comb begin
        if (sw_we)                      kind = UPD_LOAD;
        else if (op_valid && op_is_cmp) kind = UPD_CMP;
        else if (op_valid)              kind = UPD_ARITH;
        else                            kind = UPD_HOLD;
    end

    assign op_take = (kind == UPD_ARITH) || (kind == UPD_CMP);

    fpsw_flag_merge #(.W(W), .NF(NF), .LO(FLAG_LO)) u_merge (
        .word_in (word_q),
        .en      (op_take),
        .flags   (op_flags),
        .word_out(merged),
        .trap_hit(trap_hit)
    );

    fpsw_cond_update #(.W(W), .QL(QLEN), .IW(IW), .TOP(CQ_TOP), .PRIM(PRIM_BIT)) u_cond (
        .word_in (merged),
        .en      (kind == UPD_CMP),
        .rel     (cmp_rel),
        .sel     (cmp_sel),
        .idx     (cmp_idx),
        .word_out(cmp_word)
    );

    always_comb begin
        unique case (kind)
            UPD_HOLD:  word_d = word_q;
            UPD_LOAD:  word_d = sw_wdata;
            UPD_ARITH: word_d = merged;
            UPD_CMP:   word_d = cmp_word;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            trap_q <= 1'b0;
        end else begin
            word_q <= word_d;
            trap_q <= trap_hit;
        end
    end

    fpsw_mode_decode #(.W(W)) u_mode (
        .word      (word_q),
        .round_mode(round_mode),
        .flush_en  (flush_en)
    );

    assign status   = word_q;
    assign trap_req = trap_q;

    // R2: a software write always lands, whatever else is presented
    p_sw_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sw_we |=> status == $past(sw_wdata));

    // R2 and R6: trap only after an accepted operation with an enabled flag
    p_trap_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !sw_we && |(op_flags & status[NF-1:0])) |=> trap_req);
    p_trap_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && !sw_we) |=> !trap_req);

    // R4: sticky flags never clear without a write
    p_flags_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_we |=> (status[FHI:FLAG_LO] & $past(status[FHI:FLAG_LO])) == $past(status[FHI:FLAG_LO]));

    // R5: flag-free arithmetic keeps the word
    p_noflag_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_is_cmp && !sw_we && op_flags == '0) |=> $stable(status));

    // R8: compares never alter the control bits below the condition field
    p_cmp_ctrl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_is_cmp && !sw_we) |=> status[CQ_TOP-QLEN-1:0] == $past(status[CQ_TOP-QLEN-1:0]));

    // R9: queued compare shifts the queue behind the primary bit
    p_queue_shift_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_is_cmp && !sw_we && cmp_idx == '0) |=>
            (status[CQ_TOP-1 -: QLEN] == $past(status[CQ_TOP -: QLEN])) &&
            (status[CQ_TOP] == $past(status[PRIM_BIT])));
endmodule

// File: tb/fpsw_unit_tb.sv
`timescale 1ns/1ps
module fpsw_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_we = 1'b0;
    logic [31:0] sw_wdata = '0;
    logic        op_valid = 1'b0;
    logic        op_is_cmp = 1'b0;
    logic [4:0]  op_flags = '0;
    logic [1:0]  cmp_rel = '0;
    logic [4:0]  cmp_sel = '0;
    logic [3:0]  cmp_idx = '0;
    logic [31:0] status;
    logic [1:0]  round_mode;
    logic        flush_en;
    logic        trap_req;

    int vectors = 0;
    int errors  = 0;
    logic [31:0] exp_word = '0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fpsw_unit u_dut (
        .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_wdata(sw_wdata),
        .op_valid(op_valid), .op_is_cmp(op_is_cmp), .op_flags(op_flags),
        .cmp_rel(cmp_rel), .cmp_sel(cmp_sel), .cmp_idx(cmp_idx),
        .status(status), .round_mode(round_mode), .flush_en(flush_en),
        .trap_req(trap_req)
    );

    function automatic logic [31:0] model_next(input logic [31:0] s, input logic we,
        input logic [31:0] wd, input logic ov, input logic ic, input logic [4:0] fl,
        input logic [1:0] rel, input logic [4:0] sel, input logic [3:0] idx);
        logic [31:0] r;
        logic c;
        if (we) return wd;
        if (!ov) return s;
        r = s;
        r[31:27] = s[31:27] | fl;
        if (ic) begin
            c = (rel == 2'd0) ? sel[4] : (rel == 2'd1) ? sel[3] : (rel == 2'd2) ? sel[2] : sel[1];
            if (idx == 4'd0) begin
                for (int b = 11; b <= 20; b++) r[b] = s[b+1];
                r[21] = s[26];
                r[26] = c;
            end else if (idx <= 4'd11) begin
                r[22 - idx] = c;
            end
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(input string tag, input logic we, input logic [31:0] wd,
        input logic ov, input logic ic, input logic [4:0] fl, input logic [1:0] rel,
        input logic [4:0] sel, input logic [3:0] idx);
        logic [31:0] nxt;
        logic        etrap;
        sw_we = we; sw_wdata = wd; op_valid = ov; op_is_cmp = ic;
        op_flags = fl; cmp_rel = rel; cmp_sel = sel; cmp_idx = idx;
        nxt   = model_next(exp_word, we, wd, ov, ic, fl, rel, sel, idx);
        etrap = !we && ov && |(fl & exp_word[4:0]);
        @(posedge clk);
        #1;
        exp_word = nxt;
        check(tag, status, exp_word);
        check("R6", {31'b0, trap_req}, {31'b0, etrap});
        check("R3", {29'b0, flush_en, round_mode}, {29'b0, exp_word[5], exp_word[10:9]});
        sw_we = 1'b0; op_valid = 1'b0;
    endtask

    initial begin
        int unsigned seed;
        logic [31:0] w;
        logic        ic;
        logic [3:0]  ix;
        logic [4:0]  fl;
        string       tg;
        seed = 32'd7351;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        #1;
        check("R1", status, 32'h0);
        check("R1", {31'b0, trap_req}, 32'h0);
        rst_n = 1'b1;

        // R3: each rounding mode and the flush bit
        for (int m = 0; m < 4; m++)
            apply("R3", 1, 32'(m) << 9, 0, 0, 0, 0, 0, 0);
        apply("R3", 1, 32'h0000_0020, 0, 0, 0, 0, 0, 0);

        // R5: no flags leaves the word
        apply("R2", 1, 32'h0A5A_5A40, 0, 0, 0, 0, 0, 0);
        apply("R5", 0, 0, 1, 0, 5'b0, 0, 0, 0);

        // R4: flags stick; R6 trap on enabled flag (enable bit 2 overflow)
        apply("R2", 1, 32'h0000_0004, 0, 0, 0, 0, 0, 0);
        apply("R4", 0, 0, 1, 0, 5'b00001, 0, 0, 0);
        apply("R4", 0, 0, 1, 0, 5'b00100, 0, 0, 0);
        apply("R4", 0, 0, 1, 0, 5'b00000, 0, 0, 0);

        // R2: write beats an operation in the same cycle
        apply("R2", 1, 32'h0000_001F, 1, 0, 5'b11111, 0, 0, 0);

        // R7: each relation, with signaling bit both ways
        apply("R2", 1, 32'h0, 0, 0, 0, 0, 0, 0);
        apply("R7", 0, 0, 1, 1, 0, 2'd0, 5'b10000, 4'd1);
        apply("R7", 0, 0, 1, 1, 0, 2'd1, 5'b01001, 4'd2);
        apply("R7", 0, 0, 1, 1, 0, 2'd2, 5'b00100, 4'd3);
        apply("R7", 0, 0, 1, 1, 0, 2'd3, 5'b00011, 4'd4);
        apply("R7", 0, 0, 1, 1, 0, 2'd3, 5'b11101, 4'd5);

        // R8: lowest and highest targets
        apply("R8", 0, 0, 1, 1, 0, 2'd2, 5'b00100, 4'd11);
        apply("R8", 0, 0, 1, 1, 0, 2'd2, 5'b00000, 4'd1);

        // R9: queued compares
        apply("R9", 0, 0, 1, 1, 0, 2'd0, 5'b10000, 4'd0);
        apply("R9", 0, 0, 1, 1, 0, 2'd1, 5'b00000, 4'd0);
        apply("R9", 0, 0, 1, 1, 0, 2'd1, 5'b01000, 4'd0);

        // R10: compare raising an enabled flag
        apply("R2", 1, 32'h0020_0010, 0, 0, 0, 0, 0, 0);
        apply("R10", 0, 0, 1, 1, 5'b10000, 2'd3, 5'b00010, 4'd0);

        // R11: out-of-range index
        apply("R11", 0, 0, 1, 1, 5'b00010, 2'd2, 5'b00100, 4'd13);
        apply("R11", 0, 0, 1, 1, 0, 2'd0, 5'b11111, 4'd15);

        // seeded random traffic
        for (int n = 0; n < 3000; n++) begin
            w  = $urandom;
            ic = $urandom_range(0, 1) == 1;
            ix = 4'($urandom_range(0, 15));
            fl = ($urandom_range(0, 3) == 0) ? 5'($urandom) : 5'b0;
            if ($urandom_range(0, 9) == 0)  tg = "R2";
            else if (!ic)                   tg = (fl == 0) ? "R5" : "R4";
            else if (ix == 0)               tg = "R9";
            else if (ix <= 11)              tg = "R8";
            else                            tg = "R11";
            apply(tg, tg == "R2", w, $urandom_range(0, 2) != 0, ic, fl,
                  2'($urandom), 5'($urandom), ix);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                #400000;
                errors++;
                $display("FAIL watchdog: actual hung expected finished");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule